// File: doc/BRIEF.md
# Power-Domain Head-Switch Sequencer

This block powers one switchable logic domain up and down. It closes and opens two groups of head switches: a small first group that limits inrush, then the remaining group. It also gates the domain clock and drives the IO clamp that isolates the domain's outputs while it is unpowered. Each step of a transition is held for a programmable wait of 2^n ticks of a reference clock, where n is a 4-bit exponent in the control register. The reference clock arrives as a one-cycle tick strobe `ref_tick_i`, synchronous to `clk`.

Software drives the block through a small register bus. Writes are registered and reads are combinational. The collapse request comes either from a control bit or, in hardware-trigger mode, from the `hw_collapse_i` pin. Each new request first spends a fixed lag of `LAG_TICKS` (default 8) reference ticks before anything moves, and the status still shows the old state during that lag. A software override bit skips the timed sequence altogether. Separate registers hold the IO clamp, pulse an always-on reset, and drive the retention outputs.

Register map, with `ADDR_W` = 4 and 32-bit data:
- 0x0 control: bit 0 collapse (1 = off), bit 1 hardware trigger, bit 2 override, [15:12] clock-disable wait, [19:16] first-group wait, [23:20] remaining-group wait, bit 31 read-only power-on.
- 0x4 config/status: bit 16 up-complete (read-only), bit 15 down-complete (read-only), bit 11 flip-flop retention.
- 0x8 clamp: bit 0 clamp hold, bit 4 always-on reset.
- 0xC retention: bit 14 memory, bit 13 peripheral.

Top module: `pds_headswitch_seq`

## Requirements
- R1: After reset the control register reads 0x00000001 (collapsed, all wait exponents 0, power-on bit 31 = 0). Config bit 15 reads 1 and bit 16 reads 0, the clamp register reads 0x00000001, `io_clamp_o` = 1, and `sw_few_o`, `sw_rest_o`, `clk_en_o` and `aon_rst_o` are 0.
- R2: When the effective collapse request drops to 0 while the domain is off, the sequence is as follows. Taking the control write as cycle 0 with a tick every cycle, `sw_few_o` rises in cycle 1+LAG_TICKS. `sw_rest_o` rises 2^F cycles later, where F is bits [19:16]. After a further 2^R cycles, where R is bits [23:20], `clk_en_o` rises, the sequencer's clamp releases, and control bit 31 goes to 1, all in the same cycle.
- R3: When the effective request rises to 1 while the domain is on, `clk_en_o` falls in cycle 1+LAG_TICKS. After 2^C cycles, where C is bits [15:12], both switch groups open, the clamp asserts and bit 31 clears, all together.
- R4: A request withdrawn before its LAG_TICKS lag expires has no effect: the switches, the clock enable and the status never change.
- R5: Lag and wait counters advance only on cycles where `ref_tick_i` = 1.
- R6: With control bit 1 = 1, the collapse request is the `hw_collapse_i` pin (1 = off) and control bit 0 is ignored.
- R7: Changing control bit 1 while the domain is not off forces a full power-down followed by a power-up, provided the new request asks for on.
- R8: With control bit 2 = 1, the outputs and the status move to the final on or off state one cycle after the request, with no lag and no waits.
- R9: Clamp register bit 0 = 1 forces `io_clamp_o` = 1 whatever the sequencer state. Clamp register bit 4 drives `aon_rst_o` directly.
- R10: Config bit 11 drives `ff_retain_o`. Retention register bits 14 and 13 drive `mem_retain_o` and `periph_retain_o`.
- R11: Control bit 31 and config bits 16 and 15 are read-only: writes to them are ignored.
- R12: From the end of the lag until the transition completes, config bits 16 and 15 both read 0. Afterwards exactly the bit for the new state reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock period |
| hw_collapse_i | input | 1 | Hardware collapse request, 1 = power off |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| clk_en_o | output | 1 | Domain clock enable |
| io_clamp_o | output | 1 | IO clamp, 1 = outputs isolated |
| sw_few_o | output | 1 | First head-switch group closed |
| sw_rest_o | output | 1 | Remaining head-switch group closed |
| aon_rst_o | output | 1 | Always-on reset level |
| ff_retain_o | output | 1 | Flip-flop retention enable |
| mem_retain_o | output | 1 | Memory retention |
| periph_retain_o | output | 1 | Peripheral retention |

## Verification
The bench sweeps all three wait exponents over 0 to 3 and times the edge of every output against 2^n arithmetic. An off-by-one counter, a swapped wait field or a reordered step shows up directly as a wrong edge cycle. It withdraws requests inside the lag window, where a design that starts moving at once would toggle the switches or the clock. It also freezes the tick, where a design counting raw clocks would finish early. It changes the trigger mode on a live domain, where a design without the recycle would stay on with no power cycle. It exercises the override and the clamp hold, where a wrong priority would leave the clamp released or keep the waits in the path.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int DATA_W = 32;
    localparam int WAIT_W = 4;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_CFG   = 4;
    localparam int ADDR_CLAMP = 8;
    localparam int ADDR_RET   = 12;

    localparam int CTL_COLLAPSE = 0;
    localparam int CTL_HW_EN    = 1;
    localparam int CTL_OVR      = 2;
    localparam int CTL_CLK_LSB  = 12;
    localparam int CTL_FEW_LSB  = 16;
    localparam int CTL_REST_LSB = 20;
    localparam int CTL_PWR_ON   = 31;

    localparam int CFG_UP_DONE  = 16;
    localparam int CFG_DN_DONE  = 15;
    localparam int CFG_FF_RET   = 11;

    localparam int CLP_HOLD     = 0;
    localparam int CLP_AON_RST  = 4;

    localparam int RET_MEM      = 14;
    localparam int RET_PERIPH   = 13;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LAG_UP,
        ST_FEW,
        ST_REST,
        ST_ON,
        ST_LAG_DN,
        ST_CLK_WAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       clk_en;
        logic       clamp;
        logic       few;
        logic       rest;
        logic       pwr_on;
        logic       up_done;
        logic       down_done;
        logic       recycle;
        logic       hw_prev;
    } seq_reg_t;

    typedef struct packed {
        logic              collapse;
        logic              hw_en;
        logic              ovr;
        logic [WAIT_W-1:0] w_clk;
        logic [WAIT_W-1:0] w_few;
        logic [WAIT_W-1:0] w_rest;
        logic              ff_ret;
        logic              clamp_hold;
        logic              aon_rst;
        logic              mem_ret;
        logic              per_ret;
    } reg_file_t;

endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pwr_on_i,
    input  logic              up_done_i,
    input  logic              down_done_i,
    output reg_file_t         regs_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(ADDR_CFG);
    localparam logic [ADDR_W-1:0] A_CLAMP = ADDR_W'(ADDR_CLAMP);
    localparam logic [ADDR_W-1:0] A_RET   = ADDR_W'(ADDR_RET);

    reg_file_t rf_d, rf_q;
    logic      wdata_unused;

    assign wdata_unused = ^wdata_i;

    always_comb begin
        rf_d = rf_q;
        if (wr_i) begin
            case (addr_i)
                A_CTRL: begin
                    rf_d.collapse = wdata_i[CTL_COLLAPSE];
                    rf_d.hw_en    = wdata_i[CTL_HW_EN];
                    rf_d.ovr      = wdata_i[CTL_OVR];
                    rf_d.w_clk    = wdata_i[CTL_CLK_LSB +: WAIT_W];
                    rf_d.w_few    = wdata_i[CTL_FEW_LSB +: WAIT_W];
                    rf_d.w_rest   = wdata_i[CTL_REST_LSB +: WAIT_W];
                end
                A_CFG: begin
                    rf_d.ff_ret = wdata_i[CFG_FF_RET];
                end
                A_CLAMP: begin
                    rf_d.clamp_hold = wdata_i[CLP_HOLD];
                    rf_d.aon_rst    = wdata_i[CLP_AON_RST];
                end
                A_RET: begin
                    rf_d.mem_ret = wdata_i[RET_MEM];
                    rf_d.per_ret = wdata_i[RET_PERIPH];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q            <= '0;
            rf_q.collapse   <= 1'b1;
            rf_q.clamp_hold <= 1'b1;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[CTL_COLLAPSE]               = rf_q.collapse;
                rdata_o[CTL_HW_EN]                  = rf_q.hw_en;
                rdata_o[CTL_OVR]                    = rf_q.ovr;
                rdata_o[CTL_CLK_LSB +: WAIT_W]      = rf_q.w_clk;
                rdata_o[CTL_FEW_LSB +: WAIT_W]      = rf_q.w_few;
                rdata_o[CTL_REST_LSB +: WAIT_W]     = rf_q.w_rest;
                rdata_o[CTL_PWR_ON]                 = pwr_on_i;
            end
            A_CFG: begin
                rdata_o[CFG_UP_DONE] = up_done_i;
                rdata_o[CFG_DN_DONE] = down_done_i;
                rdata_o[CFG_FF_RET]  = rf_q.ff_ret;
            end
            A_CLAMP: begin
                rdata_o[CLP_HOLD]    = rf_q.clamp_hold;
                rdata_o[CLP_AON_RST] = rf_q.aon_rst;
            end
            A_RET: begin
                rdata_o[RET_MEM]    = rf_q.mem_ret;
                rdata_o[RET_PERIPH] = rf_q.per_ret;
            end
            default: ;
        endcase
    end

    assign regs_o = rf_q;

endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
    parameter int CNT_W     = 16,
    parameter int WAIT_W    = 4,
    parameter int LAG_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic              lag_sel_i,
    input  logic [WAIT_W-1:0] exp_i,
    output logic              done_o
);

    localparam logic [CNT_W-1:0] LAG_LAST = CNT_W'(LAG_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        if (lag_sel_i) begin
            limit = LAG_LAST;
        end else begin
            limit = (CNT_W'(1) << exp_i) - CNT_W'(1);
        end
        done_o = tick_i && (cnt_q == limit);
        if (restart_i || done_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_collapse_i,
    input  logic              hw_en_i,
    input  logic              hw_collapse_i,
    input  logic              ovr_i,
    input  logic [WAIT_W-1:0] w_clk_i,
    input  logic [WAIT_W-1:0] w_few_i,
    input  logic [WAIT_W-1:0] w_rest_i,
    input  logic              tdone_i,
    output logic              restart_o,
    output logic              lag_sel_o,
    output logic [WAIT_W-1:0] exp_o,
    output logic              clk_en_o,
    output logic              clamp_o,
    output logic              few_o,
    output logic              rest_o,
    output logic              pwr_on_o,
    output logic              up_done_o,
    output logic              down_done_o
);

    seq_reg_t s_d, s_q;
    logic     col;
    logic     toggle_live;
    logic     go_down;

    always_comb begin
        col         = hw_en_i ? hw_collapse_i : sw_collapse_i;
        toggle_live = (hw_en_i != s_q.hw_prev) && (s_q.st != ST_OFF);
        go_down     = col || s_q.recycle || toggle_live;

        s_d         = s_q;
        s_d.hw_prev = hw_en_i;
        if (toggle_live) begin
            s_d.recycle = 1'b1;
        end

        if (ovr_i) begin
            s_d.recycle = 1'b0;
            if (col) begin
                s_d.st        = ST_OFF;
                s_d.clk_en    = 1'b0;
                s_d.clamp     = 1'b1;
                s_d.few       = 1'b0;
                s_d.rest      = 1'b0;
                s_d.pwr_on    = 1'b0;
                s_d.up_done   = 1'b0;
                s_d.down_done = 1'b1;
            end else begin
                s_d.st        = ST_ON;
                s_d.clk_en    = 1'b1;
                s_d.clamp     = 1'b0;
                s_d.few       = 1'b1;
                s_d.rest      = 1'b1;
                s_d.pwr_on    = 1'b1;
                s_d.up_done   = 1'b1;
                s_d.down_done = 1'b0;
            end
        end else begin
            case (s_q.st)
                ST_OFF: begin
                    if (!col) begin
                        s_d.st = ST_LAG_UP;
                    end
                end
                ST_LAG_UP: begin
                    if (col) begin
                        s_d.st = ST_OFF;
                    end else if (tdone_i) begin
                        s_d.st        = ST_FEW;
                        s_d.few       = 1'b1;
                        s_d.up_done   = 1'b0;
                        s_d.down_done = 1'b0;
                    end
                end
                ST_FEW: begin
                    if (tdone_i) begin
                        s_d.st   = ST_REST;
                        s_d.rest = 1'b1;
                    end
                end
                ST_REST: begin
                    if (tdone_i) begin
                        s_d.st      = ST_ON;
                        s_d.clamp   = 1'b0;
                        s_d.clk_en  = 1'b1;
                        s_d.pwr_on  = 1'b1;
                        s_d.up_done = 1'b1;
                    end
                end
                ST_ON: begin
                    if (go_down) begin
                        s_d.st = ST_LAG_DN;
                    end
                end
                ST_LAG_DN: begin
                    if (!go_down) begin
                        s_d.st = ST_ON;
                    end else if (tdone_i) begin
                        s_d.st        = ST_CLK_WAIT;
                        s_d.clk_en    = 1'b0;
                        s_d.up_done   = 1'b0;
                        s_d.down_done = 1'b0;
                    end
                end
                ST_CLK_WAIT: begin
                    if (tdone_i) begin
                        s_d.st        = ST_OFF;
                        s_d.clamp     = 1'b1;
                        s_d.few       = 1'b0;
                        s_d.rest      = 1'b0;
                        s_d.pwr_on    = 1'b0;
                        s_d.down_done = 1'b1;
                        s_d.recycle   = 1'b0;
                    end
                end
                default: begin
                    s_d.st = ST_OFF;
                end
            endcase
        end

        restart_o = (s_d.st != s_q.st);
        lag_sel_o = (s_q.st == ST_LAG_UP) || (s_q.st == ST_LAG_DN);
        case (s_q.st)
            ST_FEW:  exp_o = w_few_i;
            ST_REST: exp_o = w_rest_i;
            default: exp_o = w_clk_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.st        <= ST_OFF;
            s_q.clamp     <= 1'b1;
            s_q.down_done <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_en_o    = s_q.clk_en;
    assign clamp_o     = s_q.clamp;
    assign few_o       = s_q.few;
    assign rest_o      = s_q.rest;
    assign pwr_on_o    = s_q.pwr_on;
    assign up_done_o   = s_q.up_done;
    assign down_done_o = s_q.down_done;

endmodule

// File: rtl/pds_headswitch_seq.sv
module pds_headswitch_seq
    import pds_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LAG_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              hw_collapse_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              clk_en_o,
    output logic              io_clamp_o,
    output logic              sw_few_o,
    output logic              sw_rest_o,
    output logic              aon_rst_o,
    output logic              ff_retain_o,
    output logic              mem_retain_o,
    output logic              periph_retain_o
);

    localparam int CNT_W = 2 ** WAIT_W;

    reg_file_t         cfg_q;
    logic              seq_clk_en;
    logic              seq_clamp;
    logic              seq_few;
    logic              seq_rest;
    logic              seq_pwr_on;
    logic              seq_up;
    logic              seq_dn;
    logic              t_restart;
    logic              t_lag_sel;
    logic [WAIT_W-1:0] t_exp;
    logic              t_done;

    pds_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .pwr_on_i    (seq_pwr_on),
        .up_done_i   (seq_up),
        .down_done_i (seq_dn),
        .regs_o      (cfg_q),
        .rdata_o     (bus_rdata_o)
    );

    pds_wait_timer #(
        .CNT_W     (CNT_W),
        .WAIT_W    (WAIT_W),
        .LAG_TICKS (LAG_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (ref_tick_i),
        .restart_i (t_restart),
        .lag_sel_i (t_lag_sel),
        .exp_i     (t_exp),
        .done_o    (t_done)
    );

    pds_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_collapse_i (cfg_q.collapse),
        .hw_en_i       (cfg_q.hw_en),
        .hw_collapse_i (hw_collapse_i),
        .ovr_i         (cfg_q.ovr),
        .w_clk_i       (cfg_q.w_clk),
        .w_few_i       (cfg_q.w_few),
        .w_rest_i      (cfg_q.w_rest),
        .tdone_i       (t_done),
        .restart_o     (t_restart),
        .lag_sel_o     (t_lag_sel),
        .exp_o         (t_exp),
        .clk_en_o      (seq_clk_en),
        .clamp_o       (seq_clamp),
        .few_o         (seq_few),
        .rest_o        (seq_rest),
        .pwr_on_o      (seq_pwr_on),
        .up_done_o     (seq_up),
        .down_done_o   (seq_dn)
    );

    assign clk_en_o        = seq_clk_en;
    assign io_clamp_o      = seq_clamp | cfg_q.clamp_hold;
    assign sw_few_o        = seq_few;
    assign sw_rest_o       = seq_rest;
    assign aon_rst_o       = cfg_q.aon_rst;
    assign ff_retain_o     = cfg_q.ff_ret;
    assign mem_retain_o    = cfg_q.mem_ret;
    assign periph_retain_o = cfg_q.per_ret;

endmodule

// File: rtl/pds_checker.sv
module pds_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic ovr,
    input logic clamp_hold,
    input logic clk_en,
    input logic io_clamp,
    input logic sw_few,
    input logic sw_rest,
    input logic pwr_on,
    input logic up_done,
    input logic down_done
);

    p_rest_after_few_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rest |-> sw_few);

    p_clock_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (sw_few && sw_rest));

    p_on_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> (clk_en && up_done));

    p_gate_before_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_rest) && !$past(ovr)) |-> !$past(clk_en));

    p_clamped_when_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rest |-> io_clamp);

    p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_done && down_done));

    p_no_tick_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ref_tick) && !$past(ovr)) |-> ($stable(sw_few) && $stable(sw_rest)));

    p_hold_clamps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_hold |-> io_clamp);

endmodule

bind pds_headswitch_seq pds_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick_i),
    .ovr        (cfg_q.ovr),
    .clamp_hold (cfg_q.clamp_hold),
    .clk_en     (clk_en_o),
    .io_clamp   (io_clamp_o),
    .sw_few     (sw_few_o),
    .sw_rest    (sw_rest_o),
    .pwr_on     (seq_pwr_on),
    .up_done    (seq_up),
    .down_done  (seq_dn)
);

// File: tb/sim_pds_headswitch_seq.sv
`timescale 1ns/1ps
module sim_pds_headswitch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        hw_col = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        clk_en, io_clamp, sw_few, sw_rest, aon_rst, ff_ret, mem_ret, per_ret;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pds_headswitch_seq u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .hw_collapse_i(hw_col),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .clk_en_o(clk_en), .io_clamp_o(io_clamp),
        .sw_few_o(sw_few), .sw_rest_o(sw_rest), .aon_rst_o(aon_rst),
        .ff_retain_o(ff_ret), .mem_retain_o(mem_ret), .periph_retain_o(per_ret)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_addr = 4'd0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 4'd0;
        #1;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int c, input int f, input int r,
                                              input bit col, input bit hw, input bit ov);
        return (32'(r) << 20) | (32'(f) << 16) | (32'(c) << 12) |
               (32'(ov) << 2) | (32'(hw) << 1) | 32'(col);
    endfunction

    // Records the first cycle after the write in which each output left its start value.
    task automatic measure(input int limit, output int t_few, output int t_rest,
                           output int t_clk, output int t_clamp, output int t_pwr,
                           output logic [31:0] mid_cfg);
        logic f0, r0, c0, k0, p0;
        logic [31:0] v;
        f0 = sw_few; r0 = sw_rest; c0 = clk_en; k0 = io_clamp; p0 = bus_rdata[31];
        t_few = -1; t_rest = -1; t_clk = -1; t_clamp = -1; t_pwr = -1; mid_cfg = '0;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk);
            #1;
            if (t_few   < 0 && sw_few   != f0) t_few   = n;
            if (t_rest  < 0 && sw_rest  != r0) t_rest  = n;
            if (t_clk   < 0 && clk_en   != c0) t_clk   = n;
            if (t_clamp < 0 && io_clamp != k0) t_clamp = n;
            if (t_pwr   < 0 && bus_rdata[31] != p0) t_pwr = n;
            if (n == 9) begin
                bus_read(4'd4, v);
                mid_cfg = v;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int tf, tr, tc, tk, tp;
        logic [31:0] mc;
        int up_t, dn_t;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        bus_read(4'd0, v); chk("R1 ctrl reset", int'(v), 1);
        bus_read(4'd4, v); chk("R1 cfg flags", int'(v[16:15]), 1);
        bus_read(4'd8, v); chk("R1 clamp reg", int'(v), 1);
        chk("R1 io_clamp", int'(io_clamp), 1);
        chk("R1 switches clk aon", int'({sw_few, sw_rest, clk_en, aon_rst}), 0);

        // R11 read-only bits ignore writes
        bus_write(4'd0, 32'h8000_0001);
        bus_read(4'd0, v); chk("R11 ctrl bit31 ignored", int'(v), 1);
        bus_write(4'd4, 32'h0001_0000);
        bus_read(4'd4, v); chk("R11 cfg done bits ignored", int'(v[16:15]), 1);

        // R9 always-on reset follows bit 4; release clamp hold
        bus_write(4'd8, 32'h0000_0010);
        chk("R9 aon reset set", int'(aon_rst), 1);
        chk("R9 sequencer clamp while off", int'(io_clamp), 1);
        bus_write(4'd8, 32'h0000_0000);
        chk("R9 aon reset clear", int'(aon_rst), 0);

        // R2 R3 R12 sweep of every exponent combination 0..3
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 4; f++) begin
                for (int r = 0; r < 4; r++) begin
                    bus_write(4'd0, ctrl_word(c, f, r, 1'b0, 1'b0, 1'b0));
                    up_t = 9 + (1 << f) + (1 << r);
                    measure(up_t + 4, tf, tr, tc, tk, tp, mc);
                    chk("R2 few edge", tf, 9);
                    chk("R2 rest edge", tr, 9 + (1 << f));
                    chk("R2 clock edge", tc, up_t);
                    chk("R2 clamp edge", tk, up_t);
                    chk("R2 status edge", tp, up_t);
                    chk("R12 flags mid power-up", int'(mc[16:15]), 0);
                    bus_read(4'd4, v); chk("R12 flags after up", int'(v[16:15]), 2);
                    bus_write(4'd0, ctrl_word(c, f, r, 1'b1, 1'b0, 1'b0));
                    dn_t = 9 + (1 << c);
                    measure(dn_t + 4, tf, tr, tc, tk, tp, mc);
                    chk("R3 clock edge", tc, 9);
                    chk("R3 few edge", tf, dn_t);
                    chk("R3 rest edge", tr, dn_t);
                    chk("R3 clamp edge", tk, dn_t);
                    chk("R3 status edge", tp, dn_t);
                    chk("R12 flags mid power-down", int'(mc[16:15]), 0);
                    bus_read(4'd4, v); chk("R12 flags after down", int'(v[16:15]), 1);
                end
            end
        end

        // R2 typical setting: clock 2, first group 8, rest 2
        bus_write(4'd0, ctrl_word(2, 8, 2, 1'b0, 1'b0, 1'b0));
        measure(9 + 256 + 4 + 4, tf, tr, tc, tk, tp, mc);
        chk("R2 typical rest edge", tr, 9 + 256);
        chk("R2 typical status edge", tp, 9 + 256 + 4);
        bus_write(4'd0, ctrl_word(2, 8, 2, 1'b1, 1'b0, 1'b0));
        measure(9 + 4 + 4, tf, tr, tc, tk, tp, mc);
        chk("R3 typical status edge", tp, 13);

        // R4 withdrawn power-up request inside the lag
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        cycles(3);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b0, 1'b0));
        measure(40, tf, tr, tc, tk, tp, mc);
        chk("R4 up abort few untouched", tf, -1);
        chk("R4 up abort status untouched", tp, -1);

        // R4 withdrawn power-down request inside the lag
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        cycles(20);
        chk("R4 domain on before down abort", int'(bus_rdata[31]), 1);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b0, 1'b0));
        cycles(3);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        measure(40, tf, tr, tc, tk, tp, mc);
        chk("R4 down abort clock untouched", tc, -1);
        chk("R4 down abort status untouched", tp, -1);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b0, 1'b0));
        cycles(20);

        // R5 no reference ticks, no progress
        ref_tick = 1'b0;
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        cycles(50);
        chk("R5 few frozen without ticks", int'(sw_few), 0);
        chk("R5 status frozen without ticks", int'(bus_rdata[31]), 0);
        @(negedge clk);
        ref_tick = 1'b1;
        cycles(20);
        chk("R5 completes once ticks resume", int'(bus_rdata[31]), 1);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b0, 1'b0));
        cycles(20);

        // R6 hardware trigger follows the pin, software bit ignored
        @(negedge clk);
        hw_col = 1'b1;
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b1, 1'b0));
        cycles(60);
        chk("R6 pin holds domain off", int'(bus_rdata[31]), 0);
        @(negedge clk);
        hw_col = 1'b0;
        cycles(30);
        chk("R6 pin release powers up", int'(bus_rdata[31]), 1);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b1, 1'b0));
        cycles(40);
        chk("R6 software collapse ignored", int'(bus_rdata[31]), 1);
        @(negedge clk);
        hw_col = 1'b1;
        cycles(30);
        chk("R6 pin collapse powers down", int'(bus_rdata[31]), 0);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        cycles(30);
        chk("R6 back in software mode on", int'(bus_rdata[31]), 1);

        // R7 trigger-mode change on a live domain forces a power cycle
        @(negedge clk);
        hw_col = 1'b0;
        bus_write(4'd0, ctrl_word(1, 1, 0, 1'b0, 1'b1, 1'b0));
        up_t = 0; dn_t = 0;
        for (int n = 1; n <= 60; n++) begin
            @(posedge clk);
            #1;
            if (dn_t == 0 && bus_rdata[31] == 1'b0) dn_t = n;
            if (dn_t != 0 && up_t == 0 && bus_rdata[31] == 1'b1) up_t = n;
        end
        chk("R7 recycle power-down edge", dn_t, 9 + 2);
        chk("R7 recycle power-up edge", up_t, 11 + 9 + 2 + 1);

        // R8 override jumps straight to the final state
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b1, 1'b0, 1'b1));
        cycles(1);
        chk("R8 override off status", int'(bus_rdata[31]), 0);
        chk("R8 override off outputs", int'({sw_few, sw_rest, clk_en, io_clamp}), 1);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b1));
        cycles(1);
        chk("R8 override on status", int'(bus_rdata[31]), 1);
        chk("R8 override on outputs", int'({sw_few, sw_rest, clk_en, io_clamp}), 14);
        bus_write(4'd0, ctrl_word(0, 0, 0, 1'b0, 1'b0, 1'b0));
        cycles(30);
        chk("R8 stays on after override off", int'(bus_rdata[31]), 1);

        // R9 clamp hold forces the clamp while powered
        chk("R9 clamp released when on", int'(io_clamp), 0);
        bus_write(4'd8, 32'h0000_0001);
        chk("R9 hold forces clamp", int'(io_clamp), 1);
        bus_write(4'd8, 32'h0000_0000);
        chk("R9 hold released", int'(io_clamp), 0);

        // R10 retention outputs
        bus_write(4'd4, 32'h0000_0800);
        chk("R10 ff retain", int'(ff_ret), 1);
        bus_write(4'd12, 32'h0000_6000);
        chk("R10 mem periph retain", int'({mem_ret, per_ret}), 3);
        bus_write(4'd12, 32'h0000_4000);
        chk("R10 mem only", int'({mem_ret, per_ret}), 2);
        bus_write(4'd4, 32'h0000_0000);
        chk("R10 ff retain cleared", int'(ff_ret), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule